// File: doc/BRIEF.md
# Serial Channel Transmitter with Holding Register

This block is the transmit half of one asynchronous serial channel. Software writes a character into a single holding register; the character moves into a shift register as soon as that register is free and is then sent on the serial line. Each frame is a low start bit, the data bits least significant first, and a high stop bit. Every bit lasts a fixed number of baud ticks, and the ticks come from a baud-rate generator outside the block.

Two registered status flags tell software how to proceed. The ready flag means the holding register can take another character. The empty flag means the line has underrun: the last stop bit has gone out and nothing is waiting. The transmitter is switched on and off by separate one-cycle command strobes. A character written while the transmitter is off is dropped. A disable lets the frame already on the line finish, but the character waiting in the holding register is never sent.

Top module: `sertx_chan`

## Requirements
- R1: After reset the serial output is high, both ready and empty are 0, and the transmitter is disabled.
- R2: A frame is one start bit at 0, then DATA_W data bits with bit 0 first, then one stop bit at 1. The output is 1 whenever no frame is in progress.
- R3: Each bit lasts exactly OVERSAMPLE clock edges on which baud_tick is 1. A character written while the shift register is idle is loaded on the next clock edge, and its start bit appears at that point without waiting for a tick.
- R4: An enable strobe given while the transmitter is disabled sets ready on the next edge and leaves empty at 0.
- R5: A write while enabled stores the data and clears both ready and empty on the next edge. A write has priority over a transfer or a frame ending in the same cycle.
- R6: When the held character moves into the shift register, ready is set on that same edge.
- R7: Empty is set on the edge that ends a stop bit if the holding register is empty and the transmitter is enabled. While empty is 1, ready is also 1.
- R8: If the holding register is full when a stop bit ends, the next start bit begins on that same edge, with no idle bit time in between.
- R9: A disable strobe clears ready and empty on the next edge. While disabled, both flags stay 0 and writes are discarded without being sent.
- R10: A disable lets the frame in progress finish, and it discards a character waiting in the holding register.
- R11: If enable and disable arrive in the same cycle, disable wins.
- R12: A second write before the held character is transferred replaces it, so only the latest character is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| tx_en_cmd | input | 1 | One-cycle transmitter enable command |
| tx_dis_cmd | input | 1 | One-cycle transmitter disable command |
| baud_tick | input | 1 | Oversampling tick from the baud generator |
| txd | output | 1 | Serial output line |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_emp | output | 1 | Underrun: holding and shift registers both empty |

## Verification
Commands and writes change the flags on the first clock edge after the strobe. A load into an idle shifter takes one more edge, so the start bit and the restored ready flag appear one edge after the write. Empty rises on the edge that completes OVERSAMPLE times the frame length in ticks after the load. The bench drives inputs on falling edges and reads the outputs on the falling edge that follows the edge where each result is due. It counts ticks itself to place every bit sample in the middle of its bit time, and it checks the exact tick count from load to empty, including a run with gaps between ticks.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   localparam int SERTX_DEF_DATA_W = 8;
   localparam int SERTX_DEF_OVS    = 16;

   typedef struct packed {
      logic rdy;
      logic emp;
   } sertx_flags_t;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
   import sertx_pkg::*;
#(
   parameter int DATA_W = SERTX_DEF_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              en_cmd,
   input  logic              dis_cmd,
   input  logic              sh_ready,
   input  logic              sh_done,
   output logic              load,
   output logic [DATA_W-1:0] hold_q,
   output logic              enabled,
   output sertx_flags_t      flags
);
   logic hold_full;

   // transfer only when a character waits, the shifter is free and no disable drops it
   assign load = hold_full && sh_ready && !dis_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enabled   <= 1'b0;
         hold_full <= 1'b0;
         hold_q    <= '0;
         flags     <= '0;
      end else if (dis_cmd) begin
         enabled   <= 1'b0;
         hold_full <= 1'b0;
         flags     <= '0;
      end else begin
         if (en_cmd && !enabled) begin
            enabled   <= 1'b1;
            flags.rdy <= 1'b1;
         end
         if (enabled && wr_stb) begin
            hold_q    <= wr_data;
            hold_full <= 1'b1;
            flags     <= '0;
         end else begin
            if (load) begin
               hold_full <= 1'b0;
               flags.rdy <= 1'b1;
            end
            if (sh_done && !hold_full && enabled) begin
               flags.emp <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int DATA_W     = SERTX_DEF_DATA_W,
   parameter int OVERSAMPLE = SERTX_DEF_OVS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] data_i,
   output logic              txd,
   output logic              busy,
   output logic              ready,
   output logic              done
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int CNT_W   = $clog2(OVERSAMPLE);
   localparam int IDX_W   = $clog2(FRAME_W);

   logic [FRAME_W-1:0] frame_in;
   logic [FRAME_W-1:0] sreg;
   logic [CNT_W-1:0]   tcnt;
   logic [IDX_W-1:0]   bit_idx;
   logic               tick_last;
   logic               bit_last;

   assign frame_in[0]         = 1'b0;
   assign frame_in[FRAME_W-1] = 1'b1;
   for (genvar i = 0; i < DATA_W; i++) begin : g_frame
      assign frame_in[i+1] = data_i[i];
   end

   assign tick_last = (tcnt == CNT_W'(OVERSAMPLE - 1));
   assign bit_last  = (bit_idx == IDX_W'(FRAME_W - 1));
   assign done      = busy && tick && tick_last && bit_last;
   assign ready     = !busy || done;
   assign txd       = busy ? sreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg    <= '1;
         tcnt    <= '0;
         bit_idx <= '0;
         busy    <= 1'b0;
      end else if (load) begin
         sreg    <= frame_in;
         tcnt    <= '0;
         bit_idx <= '0;
         busy    <= 1'b1;
      end else if (busy && tick) begin
         if (tick_last) begin
            tcnt    <= '0;
            sreg    <= {1'b1, sreg[FRAME_W-1:1]};
            bit_idx <= bit_idx + IDX_W'(1);
            if (bit_last) begin
               busy <= 1'b0;
            end
         end else begin
            tcnt <= tcnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/sertx_chan.sv
module sertx_chan
   import sertx_pkg::*;
#(
   parameter int DATA_W     = SERTX_DEF_DATA_W,
   parameter int OVERSAMPLE = SERTX_DEF_OVS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_en_cmd,
   input  logic              tx_dis_cmd,
   input  logic              baud_tick,
   output logic              txd,
   output logic              tx_rdy,
   output logic              tx_emp
);
   if (DATA_W < 1) begin : g_bad_width
      $error("sertx_chan: DATA_W must be at least 1");
   end
   if (OVERSAMPLE < 2) begin : g_bad_ovs
      $error("sertx_chan: OVERSAMPLE must be at least 2");
   end

   logic              sh_load;
   logic              sh_ready;
   logic              sh_done;
   logic              sh_busy;
   logic              en_q;
   logic [DATA_W-1:0] hold_q;
   sertx_flags_t      flags;

   sertx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wr_data  (wr_data),
      .en_cmd   (tx_en_cmd),
      .dis_cmd  (tx_dis_cmd),
      .sh_ready (sh_ready),
      .sh_done  (sh_done),
      .load     (sh_load),
      .hold_q   (hold_q),
      .enabled  (en_q),
      .flags    (flags)
   );

   sertx_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) shift_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (baud_tick),
      .load   (sh_load),
      .data_i (hold_q),
      .txd    (txd),
      .busy   (sh_busy),
      .ready  (sh_ready),
      .done   (sh_done)
   );

   assign tx_rdy = flags.rdy;
   assign tx_emp = flags.emp;
endmodule

// File: rtl/sertx_chan_chk.sv
module sertx_chan_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_stb,
   input logic tx_en_cmd,
   input logic tx_dis_cmd,
   input logic txd,
   input logic tx_rdy,
   input logic tx_emp,
   input logic en_q,
   input logic sh_busy
);
   assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_busy |-> txd);

   assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sh_busy) |-> !txd);

   assert_enable_sets_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en_cmd && !tx_dis_cmd && !en_q) |=> tx_rdy);

   assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && wr_stb && !tx_dis_cmd) |=> (!tx_rdy && !tx_emp));

   assert_emp_implies_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_emp |-> tx_rdy);

   assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dis_cmd |=> (!tx_rdy && !tx_emp));

   assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (!tx_rdy && !tx_emp));
endmodule

bind sertx_chan sertx_chan_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_stb     (wr_stb),
   .tx_en_cmd  (tx_en_cmd),
   .tx_dis_cmd (tx_dis_cmd),
   .txd        (txd),
   .tx_rdy     (tx_rdy),
   .tx_emp     (tx_emp),
   .en_q       (en_q),
   .sh_busy    (sh_busy)
);

// File: tb/sertx_chan_tb_top.sv
module sertx_chan_tb_top;
   localparam int DW = 8;
   localparam int O  = 4;
   localparam int F  = DW + 2;
   localparam int WD = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          tx_en_cmd = 1'b0;
   logic          tx_dis_cmd = 1'b0;
   logic          baud_tick = 1'b1;
   logic          txd, tx_rdy, tx_emp;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit finished = 0;
   int tick_div = 1;
   int tick_ph = 0;
   int tick_seen = 0;

   logic [DW-1:0] rx_data [0:511];
   int rx_count = 0;
   int rx_bad = 0;

   always #2 clk = ~clk;

   sertx_chan #(.DATA_W(DW), .OVERSAMPLE(O)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .tx_en_cmd(tx_en_cmd), .tx_dis_cmd(tx_dis_cmd), .baud_tick(baud_tick),
      .txd(txd), .tx_rdy(tx_rdy), .tx_emp(tx_emp)
   );

   always @(negedge clk) begin
      tick_ph = (tick_ph + 1) % tick_div;
      baud_tick = (tick_div <= 1) ? 1'b1 : (tick_ph == 0);
   end

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (rst_n && baud_tick) tick_seen = tick_seen + 1;
      if (cyc == WD && !finished) begin
         checks = checks + 1;
         fails = fails + 1;
         $display("FAIL watchdog (all requirements): actual=%0d cycles expected=<%0d", cyc, WD);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // independent frame decoder, samples each bit mid-way by counting ticks
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            int t0;
            logic [DW-1:0] v;
            bit ok;
            t0 = tick_seen;
            v = '0;
            ok = 1;
            for (int b = 0; b < F; b++) begin
               while ((tick_seen - t0) < b * O + O / 2) @(negedge clk);
               if (b == 0 && txd !== 1'b0) ok = 0;
               else if (b == F - 1 && txd !== 1'b1) ok = 0;
               else if (b > 0 && b < F - 1) v[b-1] = txd;
            end
            if (!ok) rx_bad = rx_bad + 1;
            rx_data[rx_count] = v;
            rx_count = rx_count + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_wr(input logic [DW-1:0] d);
      @(negedge clk);
      wr_stb = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic pulse_cmd(input bit en, input bit dis);
      @(negedge clk);
      tx_en_cmd = en;
      tx_dis_cmd = dis;
      @(negedge clk);
      tx_en_cmd = 1'b0;
      tx_dis_cmd = 1'b0;
   endtask

   task automatic wait_emp();
      while (!tx_emp) @(negedge clk);
   endtask

   initial begin
      int n0;
      int t_l;
      logic prev;
      int bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd === 1'b1, "R1 txd", txd, 1);
      chk(tx_rdy === 1'b0, "R1 rdy", tx_rdy, 0);
      chk(tx_emp === 1'b0, "R1 emp", tx_emp, 0);

      // R9: write while disabled is discarded
      pulse_wr(8'hA5);
      chk(tx_rdy === 1'b0, "R9 rdy after disabled write", tx_rdy, 0);
      repeat (60) @(negedge clk);
      chk(rx_count == 0, "R9 no frame from disabled write", rx_count, 0);

      // R4: enable
      pulse_cmd(1, 0);
      chk(tx_rdy === 1'b1, "R4 rdy on enable", tx_rdy, 1);
      chk(tx_emp === 1'b0, "R4 emp on enable", tx_emp, 0);

      // R5, R6, R3, R7: cycle timing of one frame
      pulse_wr(8'h3C);
      chk(tx_rdy === 1'b0, "R5 rdy cleared", tx_rdy, 0);
      chk(txd === 1'b1, "R3 still idle", txd, 1);
      @(negedge clk);
      chk(tx_rdy === 1'b1, "R6 rdy on transfer", tx_rdy, 1);
      chk(txd === 1'b0, "R3 start bit", txd, 0);
      repeat (F * O - 1) @(negedge clk);
      chk(txd === 1'b1, "R2 stop bit", txd, 1);
      chk(tx_emp === 1'b0, "R7 emp not early", tx_emp, 0);
      @(negedge clk);
      chk(tx_emp === 1'b1, "R7 emp after stop", tx_emp, 1);
      chk(rx_count == 1 && rx_data[0] == 8'h3C, "R2 data 3C", rx_data[0], 8'h3C);

      // R5 write clears emp; R8 back-to-back
      pulse_wr(8'h81);
      chk(tx_emp === 1'b0, "R5 emp cleared", tx_emp, 0);
      @(negedge clk);
      pulse_wr(8'h42);
      chk(tx_rdy === 1'b0, "R5 rdy cleared while busy", tx_rdy, 0);
      prev = txd;
      while (!tx_rdy) begin
         prev = txd;
         @(negedge clk);
      end
      chk(prev === 1'b1, "R8 stop before next", prev, 1);
      chk(txd === 1'b0, "R8 no gap", txd, 0);
      chk(tx_emp === 1'b0, "R8 no emp between", tx_emp, 0);
      wait_emp();
      chk(rx_count == 3 && rx_data[1] == 8'h81 && rx_data[2] == 8'h42,
          "R8 pair", rx_data[2], 8'h42);

      // R12 overwrite
      pulse_wr(8'h11);
      @(negedge clk);
      pulse_wr(8'h22);
      pulse_wr(8'h33);
      wait_emp();
      chk(rx_count == 5, "R12 count", rx_count, 5);
      chk(rx_data[4] == 8'h33, "R12 latest sent", rx_data[4], 8'h33);

      // R11 enable+disable together: disable wins
      pulse_cmd(1, 1);
      chk(tx_rdy === 1'b0, "R11 rdy", tx_rdy, 0);
      chk(tx_emp === 1'b0, "R11 emp", tx_emp, 0);
      pulse_wr(8'h55);
      repeat (60) @(negedge clk);
      chk(rx_count == 5, "R11 disabled, write dropped", rx_count, 5);
      chk(tx_rdy === 1'b0, "R9 rdy stays low", tx_rdy, 0);
      pulse_cmd(1, 0);
      chk(tx_rdy === 1'b1, "R4 re-enable", tx_rdy, 1);

      // R10 disable mid-frame
      pulse_wr(8'h66);
      @(negedge clk);
      pulse_wr(8'h77);
      pulse_cmd(0, 1);
      chk(tx_rdy === 1'b0 && tx_emp === 1'b0, "R9 disable clears", tx_rdy, 0);
      repeat (100) @(negedge clk);
      chk(rx_count == 6, "R10 one frame finishes", rx_count, 6);
      chk(rx_data[5] == 8'h66, "R10 frame in flight", rx_data[5], 8'h66);
      chk(tx_emp === 1'b0, "R10 no emp while disabled", tx_emp, 0);
      chk(txd === 1'b1, "R2 idle high", txd, 1);
      pulse_cmd(1, 0);

      // R3 gapped ticks: exact tick count from load to emp
      tick_div = 3;
      pulse_wr(8'hC3);
      @(negedge clk);
      chk(txd === 1'b0, "R3 start with gapped ticks", txd, 0);
      t_l = tick_seen;
      wait_emp();
      chk(tick_seen - t_l == F * O, "R3 ticks per frame", tick_seen - t_l, F * O);
      chk(rx_data[6] == 8'hC3 && rx_count == 7, "R2 data C3", rx_data[6], 8'hC3);
      tick_div = 1;

      // R2 sweep of every byte value, back to back
      n0 = rx_count;
      for (int v = 0; v < 256; v++) begin
         while (!tx_rdy) @(negedge clk);
         pulse_wr(v[DW-1:0]);
      end
      wait_emp();
      chk(rx_count == n0 + 256, "R2 sweep count", rx_count, n0 + 256);
      bad = 0;
      for (int v = 0; v < 256; v++) begin
         if (rx_data[n0 + v] != v[DW-1:0]) bad++;
      end
      chk(bad == 0, "R2 sweep data mismatches", bad, 0);
      chk(rx_bad == 0, "R2 framing errors", rx_bad, 0);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule